// File: doc/BRIEF.md
# Per-Tile Supply and Clock Scaling Controller

This block picks the supply rail and the oscillator frequency code for one processor tile. Three sources can supply a target setting. A fixed configuration input has the highest priority. A software-written setting comes next. When neither of those is enabled, an automatic policy sets the target. The policy watches how often the core stalls over a fixed window of cycles and how full the core's input FIFO is. It moves the frequency one step at a time and derives the rail from that frequency.

A rail change is sequenced. The core clock is halted first. The power-gate groups of the new rail are then switched on one group at a time, with a selectable spacing between groups, which trades switch time against grid noise. The gates of the old rail are released only after every gate of the new rail is on. The clock then restarts. A frequency change that keeps the same rail is applied at once, with no halt.

Top module: `dvfs_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, both gate banks read all zeros, `clk_en_o` is 0 and `freq_o` is 0.
- R2: The target setting comes from the fixed-configuration inputs when `static_en_i` is 1. Otherwise it comes from the software inputs when `sw_en_i` is 1. Otherwise it comes from the automatic policy.
- R3: Rail codes are 0 = off, 1 = low, 2 = high, and 3 is treated as off. Once settled on the low rail, `gate_lo_o` is all ones and `gate_hi_o` is all zeros. The high rail is the mirror case. When off, both banks are zero.
- R4: On a rail change, `clk_en_o` drops in the first cycle after the clock edge that sees the new target. It stays 0 until after the old bank is released, and it is never 1 while the rail is off.
- R5: A rail change turns on every group of the new bank before any gate of the old bank is released.
- R6: New-bank groups are enabled one per interval. The interval is 1 cycle for profile 0, STEP_MED cycles (4 by default) for profile 1, and STEP_SLOW cycles (16 by default) for profiles 2 and 3. The profile is taken when the switch starts.
- R7: A frequency change that keeps the current rail appears on `freq_o` one clock edge later, and `clk_en_o` stays 1.
- R8: During a rail change `freq_o` keeps its old value. The new frequency appears together with the release of the old bank.
- R9: The policy counts stall cycles over each window of WINDOW cycles. At the end of a window it lowers the frequency by one step if the count is above STALL_HI. It raises the frequency by one step if the count is below STALL_LO. Otherwise it holds. The frequency saturates at 0 and at 2^FREQ_W-1, and it changes only at window ends.
- R10: If `fifo_lvl_i` is at least FIFO_HI at the end of a window, the policy raises the frequency whatever the stall count.
- R11: The policy selects the high rail when its frequency code is above LOW_MAX, and the low rail otherwise.
- R12: A target of off halts the clock and clears both gate banks without enabling any group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| static_en_i | input | 1 | Fixed configuration overrides all other sources |
| static_rail_i | input | 2 | Fixed rail code |
| static_freq_i | input | FREQ_W | Fixed frequency code |
| sw_en_i | input | 1 | Software setting overrides the policy |
| sw_rail_i | input | 2 | Software rail code |
| sw_freq_i | input | FREQ_W | Software frequency code |
| stall_i | input | 1 | Core stalled this cycle |
| fifo_lvl_i | input | FIFO_W | Input FIFO occupancy |
| prof_i | input | 2 | Gate ramp profile |
| gate_hi_o | output | N_GATES/GRP_SIZE | High-rail gate group enables |
| gate_lo_o | output | N_GATES/GRP_SIZE | Low-rail gate group enables |
| clk_en_o | output | 1 | Core clock run enable |
| freq_o | output | FREQ_W | Oscillator frequency code |

## Verification
The bench builds the block with 12 gates in groups of 4, which gives three groups per bank, and with a 16-cycle stall window using thresholds 12 and 4. With three groups, the spacing of every profile can be timed edge by edge, and make-before-break can be watched across whole switches. With the short window, the policy reaches both saturation ends and crosses the rail boundary in a few hundred cycles. Alternating stall cycles give a count of 8 per window, which lies inside the hysteresis band.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  typedef enum logic [1:0] {
    RAIL_OFF  = 2'd0,
    RAIL_LOW  = 2'd1,
    RAIL_HIGH = 2'd2,
    RAIL_RSVD = 2'd3
  } rail_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_HALT,
    SQ_RAMP,
    SQ_RELEASE,
    SQ_SETTLE
  } seq_state_e;
endpackage

// File: rtl/dvfs_src_sel.sv
module dvfs_src_sel
  import dvfs_pkg::*;
#(
  parameter int FREQ_W = 4
) (
  input  logic              static_en_i,
  input  logic [1:0]        static_rail_i,
  input  logic [FREQ_W-1:0] static_freq_i,
  input  logic              sw_en_i,
  input  logic [1:0]        sw_rail_i,
  input  logic [FREQ_W-1:0] sw_freq_i,
  input  rail_e             hw_rail_i,
  input  logic [FREQ_W-1:0] hw_freq_i,
  output rail_e             tgt_rail_o,
  output logic [FREQ_W-1:0] tgt_freq_o
);
  logic [1:0] raw_rail;

  always_comb begin
    if (static_en_i) begin
      raw_rail   = static_rail_i;
      tgt_freq_o = static_freq_i;
    end else if (sw_en_i) begin
      raw_rail   = sw_rail_i;
      tgt_freq_o = sw_freq_i;
    end else begin
      raw_rail   = hw_rail_i;
      tgt_freq_o = hw_freq_i;
    end
  end

  // reserved code maps to off
  always_comb begin
    case (raw_rail)
      2'd1:    tgt_rail_o = RAIL_LOW;
      2'd2:    tgt_rail_o = RAIL_HIGH;
      default: tgt_rail_o = RAIL_OFF;
    endcase
  end
endmodule

// File: rtl/dvfs_hw_policy.sv
module dvfs_hw_policy
  import dvfs_pkg::*;
#(
  parameter int FREQ_W   = 4,
  parameter int FIFO_W   = 7,
  parameter int FIFO_HI  = 48,
  parameter int WINDOW   = 1024,
  parameter int STALL_HI = 640,
  parameter int STALL_LO = 256,
  parameter int LOW_MAX  = 7,
  parameter int FREQ_RST = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic [FIFO_W-1:0] fifo_lvl_i,
  output rail_e             hw_rail_o,
  output logic [FREQ_W-1:0] hw_freq_o
);
  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [FREQ_W-1:0] FREQ_MAX = {FREQ_W{1'b1}};

  logic [CNT_W-1:0]  win_q, stall_q, stall_tot;
  logic [FREQ_W-1:0] freq_q;
  logic              win_end, fifo_hi, go_up, go_down;

  assign win_end   = (win_q == CNT_W'(WINDOW - 1));
  assign stall_tot = stall_q + CNT_W'(stall_i);
  assign fifo_hi   = (fifo_lvl_i >= FIFO_W'(FIFO_HI));
  assign go_up     = fifo_hi || (stall_tot < CNT_W'(STALL_LO));
  assign go_down   = !fifo_hi && (stall_tot > CNT_W'(STALL_HI));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= '0;
      stall_q <= '0;
      freq_q  <= FREQ_W'(FREQ_RST);
    end else if (win_end) begin
      win_q   <= '0;
      stall_q <= '0;
      if (go_up && freq_q != FREQ_MAX)   freq_q <= freq_q + 1'b1;
      else if (go_down && freq_q != '0)  freq_q <= freq_q - 1'b1;
    end else begin
      win_q   <= win_q + 1'b1;
      stall_q <= stall_tot;
    end
  end

  assign hw_freq_o = freq_q;
  assign hw_rail_o = (freq_q > FREQ_W'(LOW_MAX)) ? RAIL_HIGH : RAIL_LOW;

  // R9
  win_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(freq_q) |-> $past(win_end));
endmodule

// File: rtl/dvfs_rail_seq.sv
module dvfs_rail_seq
  import dvfs_pkg::*;
#(
  parameter int N_GRP     = 6,
  parameter int FREQ_W    = 4,
  parameter int STEP_MED  = 4,
  parameter int STEP_SLOW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rail_e             tgt_rail_i,
  input  logic [FREQ_W-1:0] tgt_freq_i,
  input  logic [1:0]        prof_i,
  output logic [N_GRP-1:0]  gate_hi_o,
  output logic [N_GRP-1:0]  gate_lo_o,
  output logic              clk_en_o,
  output logic [FREQ_W-1:0] freq_o
);
  localparam int IDX_W  = (N_GRP > 1) ? $clog2(N_GRP) : 1;
  localparam int WAIT_W = $clog2(STEP_SLOW + 1);

  seq_state_e        state_q;
  rail_e             cur_q, new_q;
  logic [FREQ_W-1:0] freq_q, nfreq_q;
  logic [N_GRP-1:0]  hi_q, lo_q;
  logic [IDX_W-1:0]  grp_q;
  logic [WAIT_W-1:0] wait_q, step_q, step_sel;

  always_comb begin
    case (prof_i)
      2'd0:    step_sel = WAIT_W'(1);
      2'd1:    step_sel = WAIT_W'(STEP_MED);
      default: step_sel = WAIT_W'(STEP_SLOW);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      cur_q   <= RAIL_OFF;
      new_q   <= RAIL_OFF;
      freq_q  <= '0;
      nfreq_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      grp_q   <= '0;
      wait_q  <= '0;
      step_q  <= WAIT_W'(1);
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (tgt_rail_i != cur_q) begin
            new_q   <= tgt_rail_i;
            nfreq_q <= tgt_freq_i;
            step_q  <= step_sel;
            state_q <= SQ_HALT;
          end else begin
            freq_q  <= tgt_freq_i;
          end
        end
        SQ_HALT: begin
          grp_q   <= '0;
          wait_q  <= '0;
          state_q <= (new_q == RAIL_OFF) ? SQ_RELEASE : SQ_RAMP;
        end
        SQ_RAMP: begin
          if (wait_q == step_q - 1'b1) begin
            wait_q <= '0;
            if (new_q == RAIL_HIGH) hi_q[grp_q] <= 1'b1;
            else                    lo_q[grp_q] <= 1'b1;
            if (grp_q == IDX_W'(N_GRP - 1)) state_q <= SQ_RELEASE;
            else                            grp_q   <= grp_q + 1'b1;
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        SQ_RELEASE: begin
          // break only after the new bank is fully made
          if (cur_q == RAIL_HIGH) hi_q <= '0;
          if (cur_q == RAIL_LOW)  lo_q <= '0;
          cur_q   <= new_q;
          freq_q  <= nfreq_q;
          state_q <= SQ_SETTLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign gate_hi_o = hi_q;
  assign gate_lo_o = lo_q;
  assign freq_o    = freq_q;
  assign clk_en_o  = (state_q == SQ_IDLE) && (cur_q != RAIL_OFF);

  // R5
  mbb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hi_q && |lo_q) |-> (&hi_q || &lo_q));

  // R4
  halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(hi_q) && $stable(lo_q)) |-> !clk_en_o);

  // R3
  bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> ((&hi_q && lo_q == '0) || (&lo_q && hi_q == '0)));

  // R8
  freq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(state_q == SQ_RAMP) |-> $stable(freq_q));
endmodule

// File: rtl/dvfs_ctrl.sv
module dvfs_ctrl
  import dvfs_pkg::*;
#(
  parameter int N_GATES   = 48,
  parameter int GRP_SIZE  = 8,
  parameter int FREQ_W    = 4,
  parameter int FIFO_W    = 7,
  parameter int FIFO_HI   = 48,
  parameter int WINDOW    = 1024,
  parameter int STALL_HI  = 640,
  parameter int STALL_LO  = 256,
  parameter int LOW_MAX   = 7,
  parameter int FREQ_RST  = 8,
  parameter int STEP_MED  = 4,
  parameter int STEP_SLOW = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           static_en_i,
  input  logic [1:0]                     static_rail_i,
  input  logic [FREQ_W-1:0]              static_freq_i,
  input  logic                           sw_en_i,
  input  logic [1:0]                     sw_rail_i,
  input  logic [FREQ_W-1:0]              sw_freq_i,
  input  logic                           stall_i,
  input  logic [FIFO_W-1:0]              fifo_lvl_i,
  input  logic [1:0]                     prof_i,
  output logic [N_GATES/GRP_SIZE-1:0]    gate_hi_o,
  output logic [N_GATES/GRP_SIZE-1:0]    gate_lo_o,
  output logic                           clk_en_o,
  output logic [FREQ_W-1:0]              freq_o
);
  localparam int N_GRP = N_GATES / GRP_SIZE;

  rail_e             hw_rail, tgt_rail;
  logic [FREQ_W-1:0] hw_freq, tgt_freq;

  dvfs_hw_policy #(
    .FREQ_W(FREQ_W), .FIFO_W(FIFO_W), .FIFO_HI(FIFO_HI), .WINDOW(WINDOW),
    .STALL_HI(STALL_HI), .STALL_LO(STALL_LO), .LOW_MAX(LOW_MAX), .FREQ_RST(FREQ_RST)
  ) u_policy (
    .clk_i(clk_i), .rst_ni(rst_ni), .stall_i(stall_i), .fifo_lvl_i(fifo_lvl_i),
    .hw_rail_o(hw_rail), .hw_freq_o(hw_freq)
  );

  dvfs_src_sel #(.FREQ_W(FREQ_W)) u_sel (
    .static_en_i(static_en_i), .static_rail_i(static_rail_i), .static_freq_i(static_freq_i),
    .sw_en_i(sw_en_i), .sw_rail_i(sw_rail_i), .sw_freq_i(sw_freq_i),
    .hw_rail_i(hw_rail), .hw_freq_i(hw_freq),
    .tgt_rail_o(tgt_rail), .tgt_freq_o(tgt_freq)
  );

  dvfs_rail_seq #(
    .N_GRP(N_GRP), .FREQ_W(FREQ_W), .STEP_MED(STEP_MED), .STEP_SLOW(STEP_SLOW)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tgt_rail_i(tgt_rail), .tgt_freq_i(tgt_freq),
    .prof_i(prof_i), .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o),
    .clk_en_o(clk_en_o), .freq_o(freq_o)
  );
endmodule

// File: tb/tb_dvfs_ctrl.sv
`timescale 1ns/1ps
module tb_dvfs_ctrl;
  localparam int NG = 3;
  localparam int FW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          static_en = 1'b1, sw_en = 1'b0, stall = 1'b0;
  logic [1:0]    static_rail = 2'd0, sw_rail = 2'd0, prof = 2'd0;
  logic [FW-1:0] static_freq = '0, sw_freq = '0;
  logic [6:0]    fifo_lvl = '0;
  logic [NG-1:0] gate_hi, gate_lo;
  logic          clk_en;
  logic [FW-1:0] freq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dvfs_ctrl #(
    .N_GATES(12), .GRP_SIZE(4), .FREQ_W(FW), .FIFO_W(7), .FIFO_HI(48),
    .WINDOW(16), .STALL_HI(12), .STALL_LO(4), .LOW_MAX(7), .FREQ_RST(8),
    .STEP_MED(4), .STEP_SLOW(16)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .static_en_i(static_en), .static_rail_i(static_rail),
    .static_freq_i(static_freq), .sw_en_i(sw_en), .sw_rail_i(sw_rail), .sw_freq_i(sw_freq),
    .stall_i(stall), .fifo_lvl_i(fifo_lvl), .prof_i(prof), .gate_hi_o(gate_hi),
    .gate_lo_o(gate_lo), .clk_en_o(clk_en), .freq_o(freq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_banks(input string req, input int rail);
    int exp_hi, exp_lo;
    exp_hi = (rail == 2) ? (1 << NG) - 1 : 0;
    exp_lo = (rail == 1) ? (1 << NG) - 1 : 0;
    chk(gate_hi == NG'(exp_hi), req, gate_hi, exp_hi);
    chk(gate_lo == NG'(exp_lo), req, gate_lo, exp_lo);
  endtask

  task automatic t_reset;
    chk(gate_hi == '0 && gate_lo == '0, "R1 gates", {gate_hi, gate_lo}, 0);
    chk(clk_en == 1'b0, "R1 clk_en", clk_en, 0);
    chk(freq == '0, "R1 freq", freq, 0);
  endtask

  task automatic t_powerup;
    static_rail = 2'd1; static_freq = 4'd3; prof = 2'd0;
    @(negedge clk);
    chk(clk_en == 1'b0, "R4 halt at start", clk_en, 0);
    wait_cyc(40);
    chk_banks("R3 low rail", 1);
    chk(clk_en == 1'b1, "R4 restart", clk_en, 1);
    chk(freq == 4'd3, "R8 freq applied", freq, 3);
  endtask

  // switch between low and high, timing every group enable
  task automatic t_switch(input logic [1:0] p, input int step, input bit to_high,
                          input logic [FW-1:0] nf);
    int t, last_t, prev, n_new, n_old, halted;
    logic [FW-1:0] of;
    bit step_ok, mbb_ok, hold_ok;
    of = freq; last_t = -1; prev = 0; halted = 0;
    step_ok = 1'b1; mbb_ok = 1'b1; hold_ok = 1'b1;
    prof = p;
    @(negedge clk);
    static_rail = to_high ? 2'd2 : 2'd1;
    static_freq = nf;
    for (t = 0; t < 400; t++) begin
      @(negedge clk);
      n_new = $countones(to_high ? gate_hi : gate_lo);
      n_old = $countones(to_high ? gate_lo : gate_hi);
      if (clk_en) break;
      halted++;
      if (n_new > prev) begin
        if (last_t >= 0 && (t - last_t) != step) begin
          step_ok = 1'b0;
          $display("  spacing %0d at cycle %0d", t - last_t, t);
        end
        last_t = t; prev = n_new;
      end
      if (n_new < NG && n_old != NG) mbb_ok = 1'b0;
      if (n_old == NG && freq != of) hold_ok = 1'b0;
    end
    chk(step_ok, "R6 group spacing", step_ok, 1);
    chk(mbb_ok, "R5 make before break", mbb_ok, 1);
    chk(hold_ok, "R8 freq held", hold_ok, 1);
    chk(halted >= NG * step, "R4 halt length", halted, NG * step);
    chk_banks("R3 banks after switch", to_high ? 2 : 1);
    chk(freq == nf, "R8 new freq", freq, nf);
  endtask

  task automatic t_freq_only;
    bit stayed;
    stayed = 1'b1;
    static_freq = 4'd11;
    @(negedge clk);
    if (!clk_en) stayed = 1'b0;
    chk(freq == 4'd11, "R7 freq next edge", freq, 11);
    chk(stayed, "R7 no halt", stayed, 1);
  endtask

  task automatic t_off;
    bit ever_on;
    ever_on = 1'b0;
    static_rail = 2'd0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (clk_en) ever_on = 1'b1;
    end
    chk(!ever_on, "R12 clock stays off", ever_on, 0);
    chk_banks("R12 off banks", 0);
    static_rail = 2'd3;
    wait_cyc(30);
    chk_banks("R3 code 3 is off", 0);
    chk(clk_en == 1'b0, "R3 code 3 clk", clk_en, 0);
    static_rail = 2'd1; static_freq = 4'd2; prof = 2'd0;
    wait_cyc(20);
    chk_banks("R3 back to low", 1);
  endtask

  task automatic t_priority;
    sw_en = 1'b1; sw_rail = 2'd2; sw_freq = 4'd9;
    static_en = 1'b1; static_rail = 2'd1; static_freq = 4'd2;
    wait_cyc(100);
    chk(freq == 4'd2, "R2 static wins freq", freq, 2);
    chk_banks("R2 static wins rail", 1);
    static_en = 1'b0;
    wait_cyc(100);
    chk(freq == 4'd9, "R2 sw wins freq", freq, 9);
    chk_banks("R2 sw wins rail", 2);
  endtask

  task automatic t_hw;
    sw_en = 1'b0; static_en = 1'b0; prof = 2'd0; fifo_lvl = 7'd0;
    stall = 1'b1;
    wait_cyc(600);
    chk(freq == 4'd0, "R9 stall heavy floor", freq, 0);
    chk_banks("R11 low rail at floor", 1);
    // 8 stalls per window: inside the band
    for (int i = 0; i < 300; i++) begin
      stall = ~stall;
      @(negedge clk);
    end
    chk(freq == 4'd0, "R9 hold at 0 in band", freq, 0);
    stall = 1'b0;
    wait_cyc(600);
    chk(freq == 4'd15, "R9 idle ceiling", freq, 15);
    chk_banks("R11 high rail at ceiling", 2);
    for (int i = 0; i < 300; i++) begin
      stall = ~stall;
      @(negedge clk);
    end
    chk(freq == 4'd15, "R9 hold at 15 in band", freq, 15);
    stall = 1'b1;
    wait_cyc(600);
    chk(freq == 4'd0, "R9 back to floor", freq, 0);
    fifo_lvl = 7'd50;
    wait_cyc(600);
    chk(freq == 4'd15, "R10 fifo full forces up", freq, 15);
    chk_banks("R11 high rail with fifo", 2);
    stall = 1'b0; fifo_lvl = 7'd0;
  endtask

  initial begin
    wait_cyc(3);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_powerup();
    t_switch(2'd0, 1, 1'b1, 4'd5);
    t_switch(2'd1, 4, 1'b0, 4'd6);
    t_switch(2'd2, 16, 1'b1, 4'd7);
    t_switch(2'd3, 16, 1'b0, 4'd8);
    t_freq_only();
    t_off();
    t_priority();
    t_hw();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule